// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block takes two operands, an operation selector and an operand width, and produces the result together with six arithmetic status flags. The supported operations are add, subtract, bitwise AND and bitwise XOR. The operand width can be 8, 16 or 32 bits. Every flag is evaluated at the selected width, except the parity flag, which always looks at the lowest result byte. The result and the freshly computed flags appear combinationally on the outputs.

A 12-bit flag register keeps the most recent flags. It loads the computed flags on a clock edge when the update enable is high. A direct write port can also set or clear chosen flag bits under a mask. When a write and an update arrive in the same cycle, the write wins. The block is meant to sit beside an integer execution path that needs architectural status bits for conditional branches and extended-precision arithmetic.

Top module: `flag_unit`

## Requirements
- R1: `result` is the operation applied to the low bits of the operands at the selected width, with every bit above that width zero. The width codes are 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. The operation codes are 0 = add, 1 = subtract (A minus B), 2 = AND and 3 = XOR.
- R2: On an add, the carry flag is set when the unsigned sum does not fit the width. On a subtract, it is set when B is greater than A as unsigned numbers (a borrow).
- R3: The overflow flag is set when the signed add or subtract result does not fit the signed range of the width.
- R4: The sign flag equals the most significant bit of the result at the selected width.
- R5: The zero flag is set exactly when the result at the selected width is zero.
- R6: The auxiliary flag is set on a carry out of bit 3 on an add, or on a borrow out of bit 3 on a subtract (the low nibble of A is below the low nibble of B).
- R7: The parity flag is set when bits 7..0 of the result hold an even number of ones, for every width.
- R8: AND and XOR clear the carry, overflow and auxiliary flags.
- R9: Flags are packed as carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7 and overflow bit 11. All other bits of both flag outputs always read zero, even after a direct write that targets them.
- R10: The flag register clears to zero while `rstN` is low. It loads `flagsNow` on a rising edge when `updEn` is high and `wrEn` is low, and holds its value otherwise.
- R11: When `wrEn` is high, each flag bit selected by `wrMask` takes the matching `wrData` bit on the rising edge. Unselected bits hold their value, and `updEn` is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 2 | Operation select |
| opWidth | input | 2 | Operand width select |
| updEn | input | 1 | Load computed flags into the register |
| wrEn | input | 1 | Direct flag write strobe |
| wrMask | input | 12 | Bits affected by a direct write |
| wrData | input | 12 | Values for a direct write |
| result | output | 32 | Operation result, zero above the width |
| flagsNow | output | 12 | Flags of the current inputs |
| flagsReg | output | 12 | Registered flags |

## Verification
The assertions check, on every cycle, the register-level rules. The register holds when it is not enabled and loads the computed flags when enabled. A write overrides an update. Unused flag bits stay zero. Logic operations leave carry, overflow and auxiliary clear, and narrow results carry no bits above their width. Only the bench scenarios can show that each flag value is arithmetically correct. The bench compares results against an integer model across widths, at the boundaries of the unsigned and signed ranges, at nibble borrows and at odd and even parity of the low byte. It also shows the masked set-and-clear behaviour in its sequences.

// File: rtl/flagcalc_pkg.sv
package flagcalc_pkg;

  localparam int DATA_W = 32;
  localparam int FLAG_W = 12;
  localparam int LANES  = 3;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  localparam logic [FLAG_W-1:0] FLAG_VALID = FLAG_W'((1 << CF_POS) | (1 << PF_POS) |
                                                     (1 << AF_POS) | (1 << ZF_POS) |
                                                     (1 << SF_POS) | (1 << OF_POS));

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } opKind_e;

  typedef struct packed {
    logic             isSub;
    logic             isLogic;
    logic             logicXor;
    logic [LANES-1:0] widthOh;
    logic             loadCalc;
    logic             loadWrite;
  } flagCtl_t;

endpackage

// File: rtl/flag_ctl.sv
module flag_ctl
  import flagcalc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opCode,
  input  logic [1:0] opWidth,
  input  logic       updEn,
  input  logic       wrEn,
  output flagCtl_t   ctl
);

  opKind_e opKind;

  always_comb begin
    opKind        = opKind_e'(opCode);
    ctl           = '0;
    ctl.isSub     = (opKind == OP_SUB);
    ctl.isLogic   = (opKind == OP_AND) || (opKind == OP_XOR);
    ctl.logicXor  = (opKind == OP_XOR);
    case (opWidth)
      2'd0:    ctl.widthOh = 3'b001;
      2'd1:    ctl.widthOh = 3'b010;
      default: ctl.widthOh = 3'b100;
    endcase
    ctl.loadCalc  = updEn;
    ctl.loadWrite = wrEn;
  end

  AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctl.widthOh) == 1); // R1

  AST_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.isSub && ctl.isLogic)); // R8

endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flagcalc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagCtl_t          ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] wrMask,
  input  logic [FLAG_W-1:0] wrData,
  output logic [DATA_W-1:0] resOut,
  output logic [FLAG_W-1:0] flagD,
  output logic [FLAG_W-1:0] flagQ
);

  logic [LANES-1:0][DATA_W-1:0] laneRes;
  logic [LANES-1:0][FLAG_W-1:0] laneFlg;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int LW = 8 << gi;
    logic [LW-1:0] aL, bL, bEff, r;
    logic [LW:0]   sumExt;
    logic          cf, of, af;
    logic [FLAG_W-1:0] f;

    always_comb begin
      aL     = opA[LW-1:0];
      bL     = opB[LW-1:0];
      bEff   = ctl.isSub ? ~bL : bL;
      sumExt = {1'b0, aL} + {1'b0, bEff} + {{LW{1'b0}}, ctl.isSub};
      if (ctl.isLogic) begin
        r  = ctl.logicXor ? (aL ^ bL) : (aL & bL);
        cf = 1'b0;
        of = 1'b0;
        af = 1'b0;
      end else begin
        r  = sumExt[LW-1:0];
        cf = sumExt[LW] ^ ctl.isSub;
        of = (aL[LW-1] == bEff[LW-1]) && (r[LW-1] != aL[LW-1]);
        af = aL[4] ^ bEff[4] ^ sumExt[4] ^ ctl.isSub;
      end
      f         = '0;
      f[CF_POS] = cf;
      f[PF_POS] = ~^r[7:0];
      f[AF_POS] = af;
      f[ZF_POS] = (r == '0);
      f[SF_POS] = r[LW-1];
      f[OF_POS] = of;
    end

    assign laneRes[gi] = DATA_W'(r);
    assign laneFlg[gi] = f;
  end

  always_comb begin
    resOut = '0;
    flagD  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ctl.widthOh[i]) begin
        resOut = resOut | laneRes[i];
        flagD  = flagD | laneFlg[i];
      end
    end
  end

  logic [FLAG_W-1:0] effMask;
  assign effMask = wrMask & FLAG_VALID;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (ctl.loadWrite) begin
      flagQ <= (flagQ & ~effMask) | (wrData & effMask);
    end else if (ctl.loadCalc) begin
      flagQ <= flagD;
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadCalc && !ctl.loadWrite) |=> $stable(flagQ)); // R10

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadCalc && !ctl.loadWrite) |=> (flagQ == $past(flagD))); // R10

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWrite |=> (((flagQ ^ $past(wrData)) & $past(wrMask) & FLAG_VALID) == '0)); // R11

  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWrite |=> (((flagQ ^ $past(flagQ)) & ~$past(wrMask)) == '0)); // R11

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ | flagD) & ~FLAG_VALID) == '0); // R9

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.isLogic |-> (!flagD[CF_POS] && !flagD[OF_POS] && !flagD[AF_POS])); // R8

  AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.widthOh[0] |-> (resOut[DATA_W-1:8] == '0)); // R1

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    flagD[ZF_POS] |-> (resOut == '0)); // R5

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagcalc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  opCode,
  input  logic [1:0]  opWidth,
  input  logic        updEn,
  input  logic        wrEn,
  input  logic [11:0] wrMask,
  input  logic [11:0] wrData,
  output logic [31:0] result,
  output logic [11:0] flagsNow,
  output logic [11:0] flagsReg
);

  flagCtl_t ctl;

  flag_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .opCode  (opCode),
    .opWidth (opWidth),
    .updEn   (updEn),
    .wrEn    (wrEn),
    .ctl     (ctl)
  );

  flag_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .wrMask (wrMask),
    .wrData (wrData),
    .resOut (result),
    .flagD  (flagsNow),
    .flagQ  (flagsReg)
  );

endmodule

// File: tb/flag_unit_tb.sv
module flag_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [1:0]  opCode, opWidth;
  logic        updEn, wrEn;
  logic [11:0] wrMask, wrData;
  logic [31:0] result;
  logic [11:0] flagsNow, flagsReg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .opWidth(opWidth), .updEn(updEn), .wrEn(wrEn), .wrMask(wrMask),
    .wrData(wrData), .result(result), .flagsNow(flagsNow), .flagsReg(flagsReg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Integer reference: returns {result, flags}
  function automatic logic [43:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] op, input logic [1:0] wd);
    int w;
    longint one, mask, am, bm, sa, sb, s, full, r, smax, smin, ones;
    logic cf, of, af;
    logic [11:0] f;
    one = 1;
    w = (wd == 2'd0) ? 8 : (wd == 2'd1) ? 16 : 32;
    mask = (one << w) - 1;
    am = longint'(a) & mask;
    bm = longint'(b) & mask;
    smax = (one << (w - 1)) - 1;
    smin = -(one << (w - 1));
    sa = (am > smax) ? am - (one << w) : am;
    sb = (bm > smax) ? bm - (one << w) : bm;
    cf = 0; of = 0; af = 0;
    case (op)
      2'd0: begin
        full = am + bm; r = full & mask; cf = (full > mask);
        s = sa + sb; of = (s > smax) || (s < smin);
        af = ((am & 15) + (bm & 15)) > 15;
      end
      2'd1: begin
        full = am - bm; r = full & mask; cf = (am < bm);
        s = sa - sb; of = (s > smax) || (s < smin);
        af = (am & 15) < (bm & 15);
      end
      2'd2: r = am & bm;
      default: r = am ^ bm;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    f = '0;
    f[0]  = cf;
    f[2]  = (ones % 2 == 0);
    f[4]  = af;
    f[6]  = (r == 0);
    f[7]  = ((r >> (w - 1)) & 1) != 0;
    f[11] = of;
    return {r[31:0], f};
  endfunction

  task automatic applyVec(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] op, input logic [1:0] wd);
    @(negedge clk);
    opA = a; opB = b; opCode = op; opWidth = wd;
    #1;
  endtask

  task automatic checkModel(input string req, input logic [31:0] a, input logic [31:0] b,
                            input logic [1:0] op, input logic [1:0] wd);
    logic [43:0] e;
    applyVec(a, b, op, wd);
    e = refModel(a, b, op, wd);
    chk({req, " result"}, result, e[43:12]);
    chk({req, " flags"}, {20'd0, flagsNow}, {20'd0, e[11:0]});
  endtask

  task automatic t_reset;
    rstN = 0; updEn = 0; wrEn = 0; wrMask = '0; wrData = '0;
    opA = '0; opB = '0; opCode = '0; opWidth = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset clears register", {20'd0, flagsReg}, 32'd0);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic t_known;
    applyVec(32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 2'd0);
    chk("R1 add8 result", result, 32'h0);
    chk("R2 R5 R6 R7 add8 wrap", {20'd0, flagsNow}, 32'h055);
    applyVec(32'h0000_007F, 32'h0000_0001, 2'd0, 2'd0);
    chk("R3 R4 R9 add8 signed overflow", {20'd0, flagsNow}, 32'h890);
    applyVec(32'h0, 32'h1, 2'd1, 2'd1);
    chk("R1 sub16 result", result, 32'h0000_FFFF);
    chk("R2 R6 sub16 borrow", {20'd0, flagsNow}, 32'h095);
    applyVec(32'h8000_0000, 32'h1, 2'd1, 2'd2);
    chk("R3 sub32 overflow", {20'd0, flagsNow}, 32'h814);
    applyVec(32'h1234_56F0, 32'hFFFF_FF0F, 2'd2, 2'd0);
    chk("R1 and8 result", result, 32'h0);
    chk("R8 and8 flags", {20'd0, flagsNow}, 32'h044);
    applyVec(32'h0000_8001, 32'h0, 2'd3, 2'd1);
    chk("R7 xor16 odd low byte", {20'd0, flagsNow}, 32'h080);
  endtask

  task automatic t_model_sweep;
    checkModel("R2 add32 carry", 32'hFFFF_FFFF, 32'h1, 2'd0, 2'd2);
    checkModel("R2 add16 no carry", 32'h0000_7FFE, 32'h1, 2'd0, 2'd1);
    checkModel("R3 add16 overflow", 32'h0000_7FFF, 32'h1, 2'd0, 2'd1);
    checkModel("R3 sub8 neg overflow", 32'h80, 32'h01, 2'd1, 2'd0);
    checkModel("R6 add8 nibble carry", 32'h0F, 32'h01, 2'd0, 2'd0);
    checkModel("R6 sub32 nibble borrow", 32'h10, 32'h01, 2'd1, 2'd3);
    checkModel("R5 sub32 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd1, 2'd2);
    checkModel("R4 xor32 sign", 32'h8000_0000, 32'h0000_00FF, 2'd3, 2'd2);
    checkModel("R7 add32 parity", 32'h0001_0002, 32'h0000_0001, 2'd0, 2'd2);
    checkModel("R8 xor8 logic", 32'hAB, 32'hFF, 2'd3, 2'd0);
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a, b;
      a = 32'h9E37_79B9 * (k + 1);
      b = 32'h85EB_CA6B ^ (a << 3);
      checkModel("R1 sweep", a, b, 2'(k), 2'(k >> 2));
    end
  endtask

  task automatic t_update;
    logic [43:0] e;
    e = refModel(32'hFF, 32'h01, 2'd0, 2'd0);
    applyVec(32'hFF, 32'h01, 2'd0, 2'd0);
    updEn = 1;
    @(posedge clk); #1;
    chk("R10 load on update", {20'd0, flagsReg}, {20'd0, e[11:0]});
    @(negedge clk);
    updEn = 0; opA = 32'h1; opB = 32'h1;
    @(posedge clk); #1;
    chk("R10 hold without update", {20'd0, flagsReg}, {20'd0, e[11:0]});
  endtask

  task automatic t_write;
    // register holds 0x055 here
    @(negedge clk);
    wrEn = 1; wrMask = 12'h803; wrData = 12'h802;
    @(posedge clk); #1;
    chk("R11 masked set/clear", {20'd0, flagsReg}, 32'h854);
    chk("R9 reserved bit stays zero", {31'd0, flagsReg[1]}, 32'd0);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic t_priority;
    @(negedge clk);
    opA = 32'h7F; opB = 32'h01; opCode = 2'd0; opWidth = 2'd0;
    updEn = 1; wrEn = 1; wrMask = 12'h040; wrData = 12'h040;
    @(posedge clk); #1;
    chk("R11 write beats update", {20'd0, flagsReg}, 32'h854);
    @(negedge clk);
    wrEn = 0; updEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_known();
    t_model_sweep();
    t_update();
    t_write();
    t_priority();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule